// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces every instruction of a small 8-bit CPU with separate program and data spaces. Each instruction takes four clock phases. The first phase always fetches the opcode. The second phase can read an operand from program space, read a byte from data space, or stay off the bus. The third phase can write a byte to data space. The fourth phase advances or reloads the program counter. The datapath supplies decoded per-instruction control bits, a jump target, a data address and write data. The sequencer returns bus addresses, active-low strobes, and timing enables for the opcode latch and the phase-driven datapath steps.

Peripherals sit in data space, so data reads and writes are the only way to reach them. Another bus master can request the bus with an active-low hold request. The request is taken only at an instruction boundary. While the hold lasts, the sequencer parks in an idle state and withdraws its address and data drivers through the enable outputs. On release it resumes with a fresh fetch.

Top module: `phase_seq`

## Requirements
- R1: While reset is held, and right after it is released: phase_o = 4'b0001 (fetch), the fetch address is 0x0000, pgm_rd_no = 0, mem_rd_no = mem_wr_no = wr_valid_no = 1, and hold_ack_no = 1.
- R2: Outside a hold, phase_o steps through 4'b0001, 4'b0010, 4'b0100, 4'b1000 (bit k marks phase k), one clock each, and then repeats. During phase 3 every strobe is high.
- R3: In phase 0, pgm_rd_no is low, addr_o carries the program counter, and op_latch_o is high.
- R4: In phase 1, op_imm_i drives a program read at program counter + 1. Otherwise, op_load_i drives a data read at data_addr_i. If both are set, the program read wins. If neither is set, no strobe is asserted. At most one of the three read/write strobes is low at any time.
- R5: In phase 2 with op_store_i set, mem_wr_no is low for the whole clock, addr_o = data_addr_i, data_o = wr_data_i and data_oe_o = 1. Without op_store_i there is no strobe and data_oe_o = 0.
- R6: wr_valid_no is low only during the second half (clock low) of a write phase. It is high during the first half.
- R7: At the end of phase 3, the program counter loads jump_addr_i if op_jump_i is set. Otherwise it advances by 2 if phase 1 made a program read, and by 1 if not. It wraps modulo 2^16.
- R8: hold_req_ni is sampled only at the end of phase 3. A request that is present only in other phases does not interrupt the instruction.
- R9: During a hold: hold_ack_no = 0, phase_o = 0, addr_oe_o = data_oe_o = 0, all strobes are high, and the program counter is kept.
- R10: The clock edge that samples hold_req_ni high while in hold ends the hold. That edge sets hold_ack_no = 1 and phase 0, and fetches at the kept program counter.
- R11: A jump and a hold taken at the same phase-3 edge both take effect: after the hold, the fetch happens at the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_imm_i | input | 1 | Instruction reads an operand from program space in phase 1 |
| op_load_i | input | 1 | Instruction reads data space in phase 1 |
| op_store_i | input | 1 | Instruction writes data space in phase 2 |
| op_jump_i | input | 1 | Jump taken at the end of phase 3 |
| jump_addr_i | input | 16 | Jump target |
| data_addr_i | input | 16 | Data-space address (index register) |
| wr_data_i | input | 8 | Byte to write |
| hold_req_ni | input | 1 | Bus hold request, active low |
| hold_ack_no | output | 1 | Bus hold acknowledge, active low |
| addr_o | output | 16 | Bus address |
| addr_oe_o | output | 1 | Address driver enable; low means high impedance |
| data_o | output | 8 | Bus write data |
| data_oe_o | output | 1 | Data driver enable; low means high impedance |
| pgm_rd_no | output | 1 | Program read strobe |
| mem_rd_no | output | 1 | Data read strobe |
| mem_wr_no | output | 1 | Data write strobe |
| wr_valid_no | output | 1 | Write-data-valid strobe, second half of the write phase |
| op_latch_o | output | 1 | Opcode latch enable |
| phase_o | output | 4 | One-hot current phase; all zero while held |

## Verification
Two things can happen at the same phase-3 edge: the program counter update (increment or jump) and the sampling of a hold request. The bench provokes this by asserting the hold request during phase 3 of a jumping instruction. It then judges the result by checking that the idle outputs appear and that the first fetch after release uses the jump target. It also lowers the request only during phase 1 to show that the request is ignored, and it keeps the request low from phase 1 onward to show that it is taken only at the boundary.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
  typedef enum logic [2:0] {
    PH_S0   = 3'd0,
    PH_S1   = 3'd1,
    PH_S2   = 3'd2,
    PH_S3   = 3'd3,
    PH_HOLD = 3'd4
  } phase_e;
  localparam int unsigned NUM_PH = 4;
endpackage

// File: rtl/phase_seq_fsm.sv
module phase_seq_fsm
  import phase_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   hold_req_ni,
  output phase_e phase_o
);
  phase_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_S0:   st_d = PH_S1;
      PH_S1:   st_d = PH_S2;
      PH_S2:   st_d = PH_S3;
      PH_S3:   st_d = hold_req_ni ? PH_S0 : PH_HOLD;
      PH_HOLD: st_d = hold_req_ni ? PH_S0 : PH_HOLD;
      default: st_d = PH_S0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PH_S0;
    else         st_q <= st_d;
  end

  assign phase_o = st_q;
endmodule

// File: rtl/phase_seq_pc.sv
module phase_seq_pc
  import phase_seq_pkg::*;
#(
  parameter int unsigned    ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              s1_pgm_i,
  input  logic              jump_i,
  input  logic [ADDR_W-1:0] jump_addr_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_q;
  logic              skip_q;

  // remember whether the operand slot consumed a program word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                skip_q <= 1'b0;
    else if (phase_i == PH_S1)  skip_q <= s1_pgm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
    end else if (phase_i == PH_S3) begin
      if (jump_i) pc_q <= jump_addr_i;
      else        pc_q <= pc_q + (skip_q ? STEP_TWO : STEP_ONE);
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/phase_seq_bus.sv
module phase_seq_bus
  import phase_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              op_imm_i,
  input  logic              op_load_i,
  input  logic              op_store_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              pgm_rd_no,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              wr_valid_no,
  output logic              op_latch_o,
  output logic              s1_pgm_o
);
  logic half_q;

  always_comb begin
    addr_o     = pc_i;
    addr_oe_o  = 1'b1;
    data_oe_o  = 1'b0;
    pgm_rd_no  = 1'b1;
    mem_rd_no  = 1'b1;
    mem_wr_no  = 1'b1;
    op_latch_o = 1'b0;
    s1_pgm_o   = 1'b0;
    unique case (phase_i)
      PH_S0: begin
        pgm_rd_no  = 1'b0;
        op_latch_o = 1'b1;
      end
      PH_S1: begin
        if (op_imm_i) begin
          pgm_rd_no = 1'b0;
          addr_o    = pc_i + ADDR_W'(1);
          s1_pgm_o  = 1'b1;
        end else if (op_load_i) begin
          mem_rd_no = 1'b0;
          addr_o    = data_addr_i;
        end
      end
      PH_S2: begin
        if (op_store_i) begin
          mem_wr_no = 1'b0;
          addr_o    = data_addr_i;
          data_oe_o = 1'b1;
        end
      end
      PH_S3: ;
      default: addr_oe_o = 1'b0;
    endcase
  end

  // falling-edge flag marks the low half of the write phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= (phase_i == PH_S2);
  end

  assign wr_valid_no = ~((phase_i == PH_S2) & op_store_i & half_q);
  assign data_o      = wr_data_i;
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import phase_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_imm_i,
  input  logic              op_load_i,
  input  logic              op_store_i,
  input  logic              op_jump_i,
  input  logic [ADDR_W-1:0] jump_addr_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hold_req_ni,
  output logic              hold_ack_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              pgm_rd_no,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              wr_valid_no,
  output logic              op_latch_o,
  output logic [NUM_PH-1:0] phase_o
);
  phase_e            phase;
  logic [ADDR_W-1:0] pc;
  logic              s1_pgm;

  phase_seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_req_ni(hold_req_ni),
    .phase_o    (phase)
  );

  phase_seq_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) i_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .s1_pgm_i   (s1_pgm),
    .jump_i     (op_jump_i),
    .jump_addr_i(jump_addr_i),
    .pc_o       (pc)
  );

  phase_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .pc_i       (pc),
    .op_imm_i   (op_imm_i),
    .op_load_i  (op_load_i),
    .op_store_i (op_store_i),
    .data_addr_i(data_addr_i),
    .wr_data_i  (wr_data_i),
    .addr_o     (addr_o),
    .addr_oe_o  (addr_oe_o),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .pgm_rd_no  (pgm_rd_no),
    .mem_rd_no  (mem_rd_no),
    .mem_wr_no  (mem_wr_no),
    .wr_valid_no(wr_valid_no),
    .op_latch_o (op_latch_o),
    .s1_pgm_o   (s1_pgm)
  );

  for (genvar k = 0; k < NUM_PH; k++) begin : g_phase_onehot
    assign phase_o[k] = (phase == phase_e'(k));
  end

  assign hold_ack_no = (phase != PH_HOLD);
endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_req_ni,
  input logic       hold_ack_no,
  input logic       addr_oe_o,
  input logic       data_oe_o,
  input logic       pgm_rd_no,
  input logic       mem_rd_no,
  input logic       mem_wr_no,
  input logic       wr_valid_no,
  input logic       op_latch_o,
  input logic [3:0] phase_o
);
  // R2
  ring_s0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 4'b0001 |=> phase_o == 4'b0010);
  // R2
  ring_s1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 4'b0010 |=> phase_o == 4'b0100);
  // R2
  ring_s2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 4'b0100 |=> phase_o == 4'b1000);
  // R3
  fetch_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 4'b0001 |-> !pgm_rd_no && op_latch_o);
  // R4
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~pgm_rd_no, ~mem_rd_no, ~mem_wr_no}) <= 1);
  // R6
  wr_valid_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_no |-> !mem_wr_no && phase_o == 4'b0100);
  // R8
  hold_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 4'b1000 && hold_ack_no |=> hold_ack_no);
  // R9
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no |-> !addr_oe_o && !data_oe_o && pgm_rd_no && mem_rd_no
                     && mem_wr_no && wr_valid_no && phase_o == 4'b0000);
  // R10
  hold_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no && hold_req_ni |=> hold_ack_no && phase_o == 4'b0001);
endmodule

bind phase_seq phase_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_req_ni(hold_req_ni),
  .hold_ack_no(hold_ack_no),
  .addr_oe_o  (addr_oe_o),
  .data_oe_o  (data_oe_o),
  .pgm_rd_no  (pgm_rd_no),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .wr_valid_no(wr_valid_no),
  .op_latch_o (op_latch_o),
  .phase_o    (phase_o)
);

// File: tb/test_phase_seq.sv
module test_phase_seq;
  typedef struct packed {
    logic        imm;
    logic        ld;
    logic        st;
    logic        jmp;
    logic [15:0] jaddr;
    logic [15:0] daddr;
    logic [7:0]  wdata;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'h00},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'h00},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h8000, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h1234, 8'hA5},
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h5555, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h00F0, 8'h3C},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'h00},
    '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0100, 16'hC0DE, 8'h81}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_imm = 1'b0, op_load = 1'b0, op_store = 1'b0, op_jump = 1'b0;
  logic [15:0] jump_addr = '0, data_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hold_req_n = 1'b1;
  logic        hold_ack_n, addr_oe, data_oe, pgm_rd_n, mem_rd_n, mem_wr_n, wr_valid_n, op_latch;
  logic [15:0] addr;
  logic [7:0]  data;
  logic [3:0]  phase;

  int checks = 0;
  int failures = 0;
  logic [15:0] pc_model = 16'h0000;

  always #4 clk = ~clk;

  phase_seq i_phase_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .op_imm_i(op_imm), .op_load_i(op_load), .op_store_i(op_store), .op_jump_i(op_jump),
    .jump_addr_i(jump_addr), .data_addr_i(data_addr), .wr_data_i(wr_data),
    .hold_req_ni(hold_req_n), .hold_ack_no(hold_ack_n),
    .addr_o(addr), .addr_oe_o(addr_oe), .data_o(data), .data_oe_o(data_oe),
    .pgm_rd_no(pgm_rd_n), .mem_rd_no(mem_rd_n), .mem_wr_no(mem_wr_n),
    .wr_valid_no(wr_valid_n), .op_latch_o(op_latch), .phase_o(phase)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic half();
    @(negedge clk); #2;
  endtask

  // hold_mode: 0 none, 1 low from phase 1 on, 2 low in phase 3, 3 pulse in phase 1 only
  task automatic run_instr(input vec_t v, input int hold_mode);
    logic [15:0] pc_next;
    op_imm = v.imm; op_load = v.ld; op_store = v.st; op_jump = v.jmp;
    jump_addr = v.jaddr; data_addr = v.daddr; wr_data = v.wdata;
    // R3 fetch phase
    check("R3 phase", {28'd0, phase}, 32'h1);
    check("R3 addr", {16'd0, addr}, {16'd0, pc_model});
    check("R3 strobes", {29'd0, pgm_rd_n, mem_rd_n, op_latch}, {29'd0, 3'b011});
    step();
    if (hold_mode == 1 || hold_mode == 3) hold_req_n = 1'b0;
    // R4 operand phase
    check("R2 phase1", {28'd0, phase}, 32'h2);
    check("R4 pgm_rd", {31'd0, pgm_rd_n}, {31'd0, ~v.imm});
    check("R4 mem_rd", {31'd0, mem_rd_n}, {31'd0, ~(v.ld & ~v.imm)});
    if (v.imm)     check("R4 addr imm", {16'd0, addr}, {16'd0, pc_model + 16'd1});
    else if (v.ld) check("R4 addr load", {16'd0, addr}, {16'd0, v.daddr});
    step();
    if (hold_mode == 3) hold_req_n = 1'b1;
    // R5, R6 write phase, first half
    check("R8 no early hold", {31'd0, hold_ack_n}, 32'h1);
    check("R5 mem_wr", {31'd0, mem_wr_n}, {31'd0, ~v.st});
    check("R5 data_oe", {31'd0, data_oe}, {31'd0, v.st});
    check("R6 first half", {31'd0, wr_valid_n}, 32'h1);
    if (v.st) begin
      check("R5 addr", {16'd0, addr}, {16'd0, v.daddr});
      check("R5 data", {24'd0, data}, {24'd0, v.wdata});
    end
    half();
    check("R6 second half", {31'd0, wr_valid_n}, {31'd0, ~v.st});
    step();
    check("R2 phase3", {28'd0, phase}, 32'h8);
    check("R2 quiet", {29'd0, pgm_rd_n, mem_rd_n, mem_wr_n}, 32'h7);
    if (hold_mode == 2) hold_req_n = 1'b0;
    pc_next = v.jmp ? v.jaddr : pc_model + (v.imm ? 16'd2 : 16'd1);
    step();
    if (hold_mode == 1 || hold_mode == 2) begin
      for (int i = 0; i < 3; i++) begin
        check("R9 ack", {31'd0, hold_ack_n}, 32'h0);
        check("R9 phase", {28'd0, phase}, 32'h0);
        check("R9 drivers", {30'd0, addr_oe, data_oe}, 32'h0);
        check("R9 strobes", {28'd0, pgm_rd_n, mem_rd_n, mem_wr_n, wr_valid_n}, 32'hF);
        if (i == 2) hold_req_n = 1'b1;
        step();
      end
      check("R10 ack release", {31'd0, hold_ack_n}, 32'h1);
    end
    pc_model = pc_next;
    check("R7 next pc", {16'd0, addr}, {16'd0, pc_model});
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #6;
    // R1 reset state
    check("R1 phase", {28'd0, phase}, 32'h1);
    check("R1 addr", {16'd0, addr}, 32'h0);
    check("R1 strobes", {28'd0, pgm_rd_n, mem_rd_n, mem_wr_n, wr_valid_n}, 32'h7);
    check("R1 ack", {31'd0, hold_ack_n}, 32'h1);
    @(posedge clk); #2;
    rst_n = 1'b1;
    check("R1 after release", {16'd0, addr}, 32'h0);

    // vector walk: R2..R7 including wrap (R7) and imm priority (R4)
    for (int n = 0; n < NV; n++) run_instr(VECS[n], 0);
    check("R7 jump target", {16'd0, pc_model}, 32'h0100);

    // R8 request only in phase 1 is ignored
    run_instr('{1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 8'h0}, 3);
    // R8 request from phase 1 taken only at end of phase 3, then R9/R10
    run_instr('{1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h2000, 8'h0}, 1);
    // R11 jump and hold at same edge
    run_instr('{1'b1, 1'b0, 1'b1, 1'b1, 16'h4321, 16'h0777, 8'h5A}, 2);
    check("R11 fetch at target", {16'd0, addr}, 32'h4321);
    run_instr('{1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 8'h0}, 0);

    // R1 reset in the middle of an instruction
    step(); step();
    rst_n = 1'b0; #1;
    check("R1 mid reset phase", {28'd0, phase}, 32'h1);
    check("R1 mid reset addr", {16'd0, addr}, 32'h0);
    check("R1 mid reset wr_valid", {31'd0, wr_valid_n}, 32'h1);
    step();
    rst_n = 1'b1;
    pc_model = 16'h0000;
    run_instr('{1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 8'h0}, 0);
    check("R7 imm step", {16'd0, pc_model}, 32'h0002);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule